// File: doc/BRIEF.md
# Conditional-Select Integer ALU Unit

This unit is the branch-free select slice of a 32-bit integer execution pipeline. Each accepted operation takes a 4-bit operation code and up to three register operands, and returns a single 32-bit result one clock later. No flags register is involved. Every condition is read directly from a register operand, and "true" means "nonzero".

The unit provides several families of operations:

- Conditional zeroing in both polarities. The data comes from operand A and the condition from operand B.
- A full conditional move with its own destination. It picks operand A or operand B according to operand C.
- Signed and unsigned minimum and maximum.
- Signed and unsigned set-less-than.
- Sign extension from a byte or a halfword.

Instruction decode, the register file, hazard logic and the surrounding pipeline belong to the caller.

Top module: `csel_alu_unit`

## Requirements
- R1: With operation code 0 (zero-if-clear), the result is operand A when operand B is nonzero, and 0 when operand B is zero.
- R2: With operation code 1 (zero-if-set), the result is 0 when operand B is nonzero, and operand A when operand B is zero.
- R3: With operation code 2 (move), the result is operand A when operand C is nonzero, and operand B otherwise. Every nonzero value of C, including exactly 1, selects A.
- R4: Operation codes 3 (signed min) and 5 (signed max) return the smaller or the larger of A and B, compared as two's-complement values. Equal operands return that value.
- R5: Operation codes 4 (unsigned min) and 6 (unsigned max) return the smaller or the larger of A and B, compared as unsigned values.
- R6: Operation codes 7 (signed set-less-than) and 8 (unsigned set-less-than) return exactly 1 when A < B and 0 otherwise. Bits 31:1 are always zero.
- R7: Operation code 9 copies bit 7 of A into bits 31:8. Operation code 10 copies bit 15 of A into bits 31:16. Each result equals a left shift of A followed by an arithmetic right shift by the same amount (24 for code 9, 16 for code 10).
- R8: Operation codes 11 to 15 return 0.
- R9: Every operation except code 2 ignores operand C. Changing C alone does not change the result.
- R10: The result and a high result-valid flag appear one clock after inValid is high. Result-valid is low after any cycle with inValid low. A synchronous active-high reset clears result-valid.
- R11: For any condition c, the move result of (x, y, c) equals the OR of the zero-if-clear result of (x, c) and the zero-if-set result of (y, c).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Accept the operation presented this cycle |
| opCode | input | 4 | Operation code (0..10 defined) |
| srcA | input | 32 | First data operand |
| srcB | input | 32 | Second data operand, or the condition for the zeroing operations |
| srcC | input | 32 | Condition for the move operation |
| outValid | output | 1 | Result valid, one cycle after inValid |
| outResult | output | 32 | Registered result |

## Verification
The assertions assume that reset is held for at least one clock before the first operation. They also assume that the operands and opCode are stable at the clock edge where inValid is high, because the result properties compare against the sampled operand values of that edge.

The bench drives every input at the falling clock edge and holds it for the whole cycle. It asserts reset for several cycles before any traffic, so every property starts from a known output-valid state.

// File: rtl/csel_pkg.sv
package csel_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ZERO_CLR = 4'd0,
    OP_ZERO_SET = 4'd1,
    OP_MOVE     = 4'd2,
    OP_MIN_S    = 4'd3,
    OP_MIN_U    = 4'd4,
    OP_MAX_S    = 4'd5,
    OP_MAX_U    = 4'd6,
    OP_LT_S     = 4'd7,
    OP_LT_U     = 4'd8,
    OP_EXT_B    = 4'd9,
    OP_EXT_H    = 4'd10
  } opKind_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;        // capture a new result this cycle
    logic selZero;     // conditional zeroing family
    logic zeroOnSet;   // zeroing polarity: 1 zeroes when condition is nonzero
    logic selMove;     // three-source move
    logic selMinMax;   // min / max family
    logic isMax;       // pick larger
    logic isSigned;    // two's-complement compare
    logic selLess;     // set-less-than
    logic selExtB;     // byte sign extension
    logic selExtH;     // halfword sign extension
  } ctlStrobe_t;

endpackage

// File: rtl/csel_ctrl.sv
module csel_ctrl
  import csel_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            inValid,
  input  logic [OP_W-1:0] opCode,
  output ctlStrobe_t      ctl,
  output logic            outValid
);

  opKind_e opKind;

  always_comb begin
    opKind        = opKind_e'(opCode);
    ctl           = '0;
    ctl.load      = inValid;
    case (opKind)
      OP_ZERO_CLR: ctl.selZero = 1'b1;
      OP_ZERO_SET: begin ctl.selZero = 1'b1; ctl.zeroOnSet = 1'b1; end
      OP_MOVE:     ctl.selMove = 1'b1;
      OP_MIN_S:    begin ctl.selMinMax = 1'b1; ctl.isSigned = 1'b1; end
      OP_MIN_U:    ctl.selMinMax = 1'b1;
      OP_MAX_S:    begin ctl.selMinMax = 1'b1; ctl.isMax = 1'b1; ctl.isSigned = 1'b1; end
      OP_MAX_U:    begin ctl.selMinMax = 1'b1; ctl.isMax = 1'b1; end
      OP_LT_S:     begin ctl.selLess = 1'b1; ctl.isSigned = 1'b1; end
      OP_LT_U:     ctl.selLess = 1'b1;
      OP_EXT_B:    ctl.selExtB = 1'b1;
      OP_EXT_H:    ctl.selExtH = 1'b1;
      default:     ; // undefined codes select nothing, so the result is zero (R8)
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end

  // R8: at most one result family is enabled
  a_r8_one_family: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctl.selZero, ctl.selMove, ctl.selMinMax, ctl.selLess, ctl.selExtB, ctl.selExtH}));

  // R10: valid follows the accept strobe by one clock
  a_r10_valid_rise: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);
  a_r10_valid_fall: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);

endmodule

// File: rtl/csel_dpath.sv
module csel_dpath
  import csel_pkg::*;
#(
  parameter int XLEN = 32
)(
  input  logic            clk,
  input  logic            rst,
  input  ctlStrobe_t      ctl,
  input  logic [XLEN-1:0] opA,
  input  logic [XLEN-1:0] opB,
  input  logic [XLEN-1:0] opC,
  output logic [XLEN-1:0] result
);

  localparam int N_EXT = 2;
  localparam int EXT_W [N_EXT] = '{8, 16};

  logic            condB, condC, lessS, lessU, less;
  logic [XLEN-1:0] zeroTerm, moveTerm, mmTerm, lessTerm, extTerm, nextResult;
  logic [XLEN-1:0] extVec [N_EXT];
  logic [N_EXT-1:0] extSel;

  assign extSel = {ctl.selExtH, ctl.selExtB};

  // One sign extender per source width
  for (genvar g = 0; g < N_EXT; g++) begin : g_ext
    localparam int W = EXT_W[g];
    assign extVec[g] = {{(XLEN-W){opA[W-1]}}, opA[W-1:0]};
  end

  always_comb begin
    condB = |opB;
    condC = |opC;
    lessS = $signed(opA) < $signed(opB);
    lessU = opA < opB;
    less  = ctl.isSigned ? lessS : lessU;

    zeroTerm = (ctl.selZero && (condB ^ ctl.zeroOnSet)) ? opA : '0;
    moveTerm = ctl.selMove ? (condC ? opA : opB) : '0;
    mmTerm   = ctl.selMinMax ? ((less ^ ctl.isMax) ? opA : opB) : '0;
    lessTerm = ctl.selLess ? XLEN'(less) : '0;

    extTerm = '0;
    for (int i = 0; i < N_EXT; i++)
      if (extSel[i]) extTerm = extTerm | extVec[i];

    nextResult = zeroTerm | moveTerm | mmTerm | lessTerm | extTerm;
  end

  always_ff @(posedge clk) begin
    if (rst)           result <= '0;
    else if (ctl.load) result <= nextResult;
  end

  // R1: zero-if-clear with a zero condition yields zero
  a_r1_clear_zero: assert property (@(posedge clk) disable iff (rst)
    (ctl.load && ctl.selZero && !ctl.zeroOnSet && opB == '0) |=> result == '0);

  // R2: zero-if-set with a nonzero condition yields zero
  a_r2_set_zero: assert property (@(posedge clk) disable iff (rst)
    (ctl.load && ctl.selZero && ctl.zeroOnSet && opB != '0) |=> result == '0);

  // R3: move with nonzero condition returns operand A
  a_r3_move_a: assert property (@(posedge clk) disable iff (rst)
    (ctl.load && ctl.selMove && opC != '0) |=> result == $past(opA));

  // R4: signed minimum never exceeds operand A
  a_r4_min_bound: assert property (@(posedge clk) disable iff (rst)
    (ctl.load && ctl.selMinMax && ctl.isSigned && !ctl.isMax)
      |=> $signed(result) <= $signed($past(opA)));

  // R5: unsigned maximum is never below operand B
  a_r5_max_bound: assert property (@(posedge clk) disable iff (rst)
    (ctl.load && ctl.selMinMax && !ctl.isSigned && ctl.isMax) |=> result >= $past(opB));

  // R6: set-less-than is a plain boolean
  a_r6_bool: assert property (@(posedge clk) disable iff (rst)
    (ctl.load && ctl.selLess) |=> result[XLEN-1:1] == '0);

  // R10: result holds when nothing is accepted
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !ctl.load |=> $stable(result));

endmodule

// File: rtl/csel_alu_unit.sv
module csel_alu_unit
  import csel_pkg::*;
#(
  parameter int XLEN = 32
)(
  input  logic            clk,
  input  logic            rst,
  input  logic            inValid,
  input  logic [3:0]      opCode,
  input  logic [XLEN-1:0] srcA,
  input  logic [XLEN-1:0] srcB,
  input  logic [XLEN-1:0] srcC,
  output logic            outValid,
  output logic [XLEN-1:0] outResult
);

  ctlStrobe_t ctl;

  csel_ctrl ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .opCode   (opCode),
    .ctl      (ctl),
    .outValid (outValid)
  );

  csel_dpath #(.XLEN(XLEN)) dpath_i (
    .clk    (clk),
    .rst    (rst),
    .ctl    (ctl),
    .opA    (srcA),
    .opB    (srcB),
    .opC    (srcC),
    .result (outResult)
  );

endmodule

// File: tb/csel_alu_unit_tb.sv
module csel_alu_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [3:0]  opCode = '0;
  logic [31:0] srcA = '0, srcB = '0, srcC = '0;
  logic        outValid;
  logic [31:0] outResult;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  typedef struct { logic [31:0] exp; int req; } sbItem_t;
  sbItem_t sb[$];

  always #10 clk = ~clk; // 50 MHz

  csel_alu_unit dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .opCode(opCode),
    .srcA(srcA), .srcB(srcB), .srcC(srcC),
    .outValid(outValid), .outResult(outResult)
  );

  // Behavioural reference; the move uses the R11 identity
  function automatic logic [31:0] refModel(logic [3:0] op, logic [31:0] a, logic [31:0] b, logic [31:0] c);
    logic [31:0] zc, zs;
    case (op)
      4'd0: return (b != 0) ? a : 32'd0;                 // R1
      4'd1: return (b != 0) ? 32'd0 : a;                 // R2
      4'd2: begin                                        // R3, R11
        zc = (c != 0) ? a : 32'd0;
        zs = (c != 0) ? 32'd0 : b;
        return zc | zs;
      end
      4'd3: return ($signed(a) < $signed(b)) ? a : b;    // R4
      4'd5: return ($signed(a) > $signed(b)) ? a : b;
      4'd4: return (a < b) ? a : b;                      // R5
      4'd6: return (a > b) ? a : b;
      4'd7: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0; // R6
      4'd8: return (a < b) ? 32'd1 : 32'd0;
      4'd9: return 32'($signed(a << 24) >>> 24);         // R7
      4'd10: return 32'($signed(a << 16) >>> 16);
      default: return 32'd0;                             // R8
    endcase
  endfunction

  function automatic int reqOf(logic [3:0] op);
    case (op)
      4'd0: return 1;
      4'd1: return 2;
      4'd2: return 3;
      4'd3, 4'd5: return 4;
      4'd4, 4'd6: return 5;
      4'd7, 4'd8: return 6;
      4'd9, 4'd10: return 7;
      default: return 8;
    endcase
  endfunction

  task automatic drive(logic [3:0] op, logic [31:0] a, logic [31:0] b, logic [31:0] c, int req = 0);
    sbItem_t it;
    @(negedge clk);
    inValid = 1'b1; opCode = op; srcA = a; srcB = b; srcC = c;
    it.exp = refModel(op, a, b, c);
    it.req = (req != 0) ? req : reqOf(op);
    sb.push_back(it);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
      srcC = $urandom;
    end
  endtask

  // Monitor: sample midway between edges
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (!rst) begin
        if (outValid) begin
          nChecks++;
          if (sb.size() == 0) begin
            nFails++;
            $display("FAIL R10: outValid high with no pending op (actual 1, expected 0)");
          end else begin
            sbItem_t it;
            it = sb.pop_front();
            if (outResult !== it.exp) begin
              nFails++;
              $display("FAIL R%0d: result actual %h expected %h", it.req, outResult, it.exp);
            end
          end
        end else if (sb.size() != 0) begin
          nChecks++; nFails++;
          $display("FAIL R10: outValid low with pending op (actual 0, expected 1)");
          void'(sb.pop_front());
        end
      end
    end
  end

  // Watchdog
  initial begin
    #3000000;
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: run did not complete (actual timeout, expected done)");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R10: reset clears valid
    nChecks++;
    if (outValid !== 1'b0) begin
      nFails++;
      $display("FAIL R10: outValid during reset actual %b expected 0", outValid);
    end
    @(negedge clk); rst = 1'b0;
    idle(2);

    // Random sweep over every code, C random too
    for (int op = 0; op < 16; op++)
      for (int k = 0; k < 20; k++)
        drive(4'(op), $urandom, $urandom, $urandom);
    idle(3);

    // R4/R5/R6 corner operands
    for (int op = 3; op <= 8; op++) begin
      drive(4'(op), 32'h8000_0000, 32'h7FFF_FFFF, 0);
      drive(4'(op), 32'h7FFF_FFFF, 32'h8000_0000, 0);
      drive(4'(op), 32'h1234_5678, 32'h1234_5678, 0); // equal operands
    end
    // R7 boundary bit patterns
    drive(4'd9, 32'h0000_0080, 0, 0);
    drive(4'd9, 32'hFFFF_FF7F, 0, 0);
    drive(4'd10, 32'h0000_8000, 0, 0);
    drive(4'd10, 32'hFFFF_7FFF, 0, 0);

    // R3/R11: condition exactly 1 versus other nonzero values, and zero
    drive(4'd2, 32'hAAAA_AAAA, 32'h5555_5555, 32'd1, 11);
    drive(4'd2, 32'hAAAA_AAAA, 32'h5555_5555, 32'h8000_0000, 11);
    drive(4'd2, 32'hAAAA_AAAA, 32'h5555_5555, 32'hFFFF_FFFF, 11);
    drive(4'd2, 32'hAAAA_AAAA, 32'h5555_5555, 32'd0, 11);
    // R1/R2 with condition 1 and a high-bit-only condition
    drive(4'd0, 32'hDEAD_BEEF, 32'd1, 0);
    drive(4'd1, 32'hDEAD_BEEF, 32'd1, 0);
    drive(4'd0, 32'hDEAD_BEEF, 32'h8000_0000, 0);
    drive(4'd1, 32'hDEAD_BEEF, 32'd0, 0);
    drive(4'd0, 32'hDEAD_BEEF, 32'd0, 0);

    // R9: same A/B with two different C values on each non-move op
    for (int op = 0; op < 16; op++) begin
      if (op != 2) begin
        logic [31:0] a, b;
        a = $urandom; b = $urandom;
        drive(4'(op), a, b, 32'd0, 9);
        drive(4'(op), a, b, 32'hFFFF_FFFF, 9);
      end
    end

    // R10: gaps in the valid stream; monitor flags any stray valid
    drive(4'd5, 32'd3, 32'd7, 0);
    idle(2);
    drive(4'd4, 32'd3, 32'd7, 0);
    idle(4);

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule